// File: doc/BRIEF.md
# Multi-Dimension Test Address Generator

This block walks the address space seen by a memory test engine. It keeps four
address counters, one each for column, row, bank and logical rank. Each counter
has its own start value, wrap value, step size and update rate. A command
sequencer pulses an advance strobe once per access. Each dimension counts those
strobes and moves by its step size once every R strobes. The rate R is encoded
either as a plain count or as a power of two.

When a step would carry a dimension past its wrap value, the dimension reloads
its start value instead. It can then optionally give the next dimension in the
nesting (column, row, bank, rank) one extra step. A wrap in a dimension whose
trigger is enabled produces a one-cycle event that the sequencer can use to end
or chain a test. A restart pulse puts every dimension back at its start value.

The logical rank is translated to a physical rank through a compacted map built
from a rank-select mask. That mask also sets how far the rank dimension counts.

Top module: `test_addr_gen`

## Requirements
- R1: After reset every address output is 0, `wrap_trig_o` is 0 and all rate counters are cleared.
- R2: A cycle with `restart_i` high loads every dimension with its start value and clears all rate counters. It takes priority over `advance_i` in the same cycle.
- R3: The column counter is 8 bits wide. `col_addr_o` presents it at bits 10:3 with bits 2:0 zero, so one column step moves the address by 8 times the increment.
- R4: Linear rate: when the rate flag is set (bit 7 of the 8-bit column, bank and rank rate fields; bit 5 of the 6-bit row rate field), the low bits N make the dimension update on every Nth advance. N = 0 means the dimension never updates on its own.
- R5: Power-of-two rate: when the rate flag is clear, the low-bit value n makes the dimension update once every 2^n advances, with n limited to 15.
- R6: On an update, if the current value plus the increment exceeds the wrap value, the dimension reloads its start value. Otherwise it takes the sum. A sum equal to the wrap value is kept.
- R7: `carry_en_i` bit 0 (column), bit 1 (row) and bit 2 (bank) let a wrap of that dimension give the next dimension exactly one step in the same cycle. A carry and an own-rate update arriving in the same cycle give one step, not two.
- R8: `trig_en_i` bit 0 column, bit 1 row, bit 2 bank, bit 3 rank: `wrap_trig_o` is high for exactly the one cycle after an advance in which an enabled dimension wrapped, and never otherwise.
- R9: `rank_map_o` holds 4 bits per logical rank at bits [4i+3:4i]. Logical rank i maps to the i-th lowest set bit of `rank_mask_i`, and unused entries are 0. The rank wrap value is the number of set bits minus 1 (0 when none are set). `phys_rank_o` is the map entry of the current logical rank.
- R10: Without `advance_i` or `restart_i`, all addresses hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Reload all dimensions with their start values |
| advance_i | input | 1 | One access issued by the sequencer |
| col_start_i | input | 8 | Column start (address bits 10:3) |
| col_wrap_i | input | 8 | Column wrap value |
| col_inc_i | input | 8 | Column increment |
| col_rate_i | input | 8 | Column update rate (bit 7 linear flag) |
| row_start_i | input | 16 | Row start |
| row_wrap_i | input | 16 | Row wrap value |
| row_inc_i | input | 12 | Row increment |
| row_rate_i | input | 6 | Row update rate (bit 5 linear flag) |
| bank_start_i | input | 3 | Bank start |
| bank_wrap_i | input | 3 | Bank wrap value |
| bank_inc_i | input | 3 | Bank increment |
| bank_rate_i | input | 8 | Bank update rate (bit 7 linear flag) |
| rank_start_i | input | 3 | Logical rank start |
| rank_inc_i | input | 3 | Logical rank increment |
| rank_rate_i | input | 8 | Rank update rate (bit 7 linear flag) |
| rank_mask_i | input | 8 | Physical ranks taking part in the test |
| carry_en_i | input | 3 | Wrap carry enables: column, row, bank |
| trig_en_i | input | 4 | Wrap trigger enables: column, row, bank, rank |
| col_addr_o | output | 11 | Column address, bits 2:0 zero |
| row_addr_o | output | 16 | Row address |
| bank_addr_o | output | 3 | Bank address |
| rank_addr_o | output | 3 | Logical rank |
| phys_rank_o | output | 4 | Physical rank for the current logical rank |
| rank_map_o | output | 32 | Logical-to-physical rank map |
| wrap_trig_o | output | 1 | One-cycle wrap trigger event |

## Verification
The hardest case to reach is a single cycle in which a dimension receives both
its own rate update and a carry from the dimension below. Both sources must
collapse into one step. The bench reaches this case by giving the column a wrap
value of 0, so every advance wraps it and carries. The row is set to update on
every advance, and its count after several advances shows whether double steps
occurred. Multi-level carry ripple is exercised by shrinking the row range to a
single value, so each column wrap ripples through the row into the bank.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
    localparam int NUM_DIMS   = 4;
    localparam int MAP_NIB_W  = 4;
    localparam int COL_SHIFT  = 3;

    typedef enum logic [1:0] {
        DIM_COL  = 2'd0,
        DIM_ROW  = 2'd1,
        DIM_BANK = 2'd2,
        DIM_RANK = 2'd3
    } dim_e;
endpackage

// File: rtl/dim_stepper.sv
module dim_stepper #(
    parameter int ADDR_W = 8,
    parameter int INC_W  = 8,
    parameter int RATE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic              advance_i,
    input  logic              carry_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] wrap_i,
    input  logic [INC_W-1:0]  inc_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);
    localparam int LOW_W = RATE_W - 1;
    localparam int SUM_W = ((ADDR_W > INC_W) ? ADDR_W : INC_W) + 1;
    localparam int EXP_MAX = CNT_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t s_d, s_q;

    logic             lin_flag;
    logic [LOW_W-1:0] low_val;
    logic [LOW_W-1:0] exp_n;
    logic [CNT_W-1:0] last_cnt;
    logic             never_upd;
    logic [SUM_W-1:0] sum;
    logic             tick;
    logic             step;
    logic             wrapped;

    // rate decode: linear count or clamped power of two
    always_comb begin
        lin_flag  = rate_i[RATE_W-1];
        low_val   = rate_i[LOW_W-1:0];
        exp_n     = (int'(low_val) > EXP_MAX) ? LOW_W'(EXP_MAX) : low_val;
        never_upd = lin_flag && (low_val == '0);
        if (lin_flag)
            last_cnt = CNT_W'(low_val) - CNT_W'(1);
        else
            last_cnt = (CNT_W'(1) << exp_n) - CNT_W'(1);
        sum = SUM_W'(s_q.addr) + SUM_W'(inc_i);
    end

    always_comb begin
        s_d     = s_q;
        tick    = 1'b0;
        step    = 1'b0;
        wrapped = 1'b0;
        if (restart_i) begin
            s_d.addr = start_i;
            s_d.cnt  = '0;
        end else begin
            if (advance_i && !never_upd) begin
                if (s_q.cnt == last_cnt) begin
                    tick    = 1'b1;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            step = tick | carry_i;
            if (step) begin
                if (sum > SUM_W'(wrap_i)) begin
                    wrapped  = 1'b1;
                    s_d.addr = start_i;
                end else begin
                    s_d.addr = sum[ADDR_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign addr_o = s_q.addr;
    assign wrap_o = wrapped;
endmodule

// File: rtl/rank_compactor.sv
module rank_compactor
    import addr_gen_pkg::*;
#(
    parameter int RANK_W = 3,
    localparam int NRANKS = 1 << RANK_W
) (
    input  logic [NRANKS-1:0]           mask_i,
    input  logic [RANK_W-1:0]           logical_i,
    output logic [NRANKS*MAP_NIB_W-1:0] map_o,
    output logic [RANK_W-1:0]           wrap_o,
    output logic [MAP_NIB_W-1:0]        phys_o
);
    logic [RANK_W:0] sel_cnt;

    always_comb begin
        map_o   = '0;
        sel_cnt = '0;
        for (int r = 0; r < NRANKS; r++) begin
            if (mask_i[r]) begin
                map_o[int'(sel_cnt)*MAP_NIB_W +: MAP_NIB_W] = MAP_NIB_W'(r);
                sel_cnt = sel_cnt + 1'b1;
            end
        end
        wrap_o = (sel_cnt == '0) ? '0 : RANK_W'(sel_cnt - 1'b1);
        phys_o = map_o[int'(logical_i)*MAP_NIB_W +: MAP_NIB_W];
    end
endmodule

// File: rtl/test_addr_gen.sv
module test_addr_gen
    import addr_gen_pkg::*;
#(
    parameter int COL_W      = 8,
    parameter int COL_INC_W  = 8,
    parameter int ROW_W      = 16,
    parameter int ROW_INC_W  = 12,
    parameter int ROW_RATE_W = 6,
    parameter int BANK_W     = 3,
    parameter int RANK_W     = 3,
    parameter int RATE_W     = 8,
    parameter int CNT_W      = 16,
    localparam int NRANKS    = 1 << RANK_W,
    localparam int CADDR_W   = COL_W + COL_SHIFT
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        restart_i,
    input  logic                        advance_i,
    input  logic [COL_W-1:0]            col_start_i,
    input  logic [COL_W-1:0]            col_wrap_i,
    input  logic [COL_INC_W-1:0]        col_inc_i,
    input  logic [RATE_W-1:0]           col_rate_i,
    input  logic [ROW_W-1:0]            row_start_i,
    input  logic [ROW_W-1:0]            row_wrap_i,
    input  logic [ROW_INC_W-1:0]        row_inc_i,
    input  logic [ROW_RATE_W-1:0]       row_rate_i,
    input  logic [BANK_W-1:0]           bank_start_i,
    input  logic [BANK_W-1:0]           bank_wrap_i,
    input  logic [BANK_W-1:0]           bank_inc_i,
    input  logic [RATE_W-1:0]           bank_rate_i,
    input  logic [RANK_W-1:0]           rank_start_i,
    input  logic [RANK_W-1:0]           rank_inc_i,
    input  logic [RATE_W-1:0]           rank_rate_i,
    input  logic [NRANKS-1:0]           rank_mask_i,
    input  logic [NUM_DIMS-2:0]         carry_en_i,
    input  logic [NUM_DIMS-1:0]         trig_en_i,
    output logic [CADDR_W-1:0]          col_addr_o,
    output logic [ROW_W-1:0]            row_addr_o,
    output logic [BANK_W-1:0]           bank_addr_o,
    output logic [RANK_W-1:0]           rank_addr_o,
    output logic [MAP_NIB_W-1:0]        phys_rank_o,
    output logic [NRANKS*MAP_NIB_W-1:0] rank_map_o,
    output logic                        wrap_trig_o
);
    logic [NUM_DIMS-1:0] dim_wrap;
    logic [NUM_DIMS-1:0] dim_carry;
    logic [COL_W-1:0]    col_q;
    logic [RANK_W-1:0]   rank_wrap;
    logic                trig_d, trig_q;

    // carry chain: column -> row -> bank -> rank
    always_comb begin
        dim_carry = '0;
        for (int d = 1; d < NUM_DIMS; d++)
            dim_carry[d] = dim_wrap[d-1] & carry_en_i[d-1];
    end

    dim_stepper #(.ADDR_W(COL_W), .INC_W(COL_INC_W), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_col (
        .clk_i, .rst_ni, .restart_i, .advance_i,
        .carry_i (dim_carry[DIM_COL]),
        .start_i (col_start_i), .wrap_i (col_wrap_i),
        .inc_i   (col_inc_i),   .rate_i (col_rate_i),
        .addr_o  (col_q),       .wrap_o (dim_wrap[DIM_COL])
    );

    dim_stepper #(.ADDR_W(ROW_W), .INC_W(ROW_INC_W), .RATE_W(ROW_RATE_W), .CNT_W(CNT_W)) u_row (
        .clk_i, .rst_ni, .restart_i, .advance_i,
        .carry_i (dim_carry[DIM_ROW]),
        .start_i (row_start_i), .wrap_i (row_wrap_i),
        .inc_i   (row_inc_i),   .rate_i (row_rate_i),
        .addr_o  (row_addr_o),  .wrap_o (dim_wrap[DIM_ROW])
    );

    dim_stepper #(.ADDR_W(BANK_W), .INC_W(BANK_W), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_bank (
        .clk_i, .rst_ni, .restart_i, .advance_i,
        .carry_i (dim_carry[DIM_BANK]),
        .start_i (bank_start_i), .wrap_i (bank_wrap_i),
        .inc_i   (bank_inc_i),   .rate_i (bank_rate_i),
        .addr_o  (bank_addr_o),  .wrap_o (dim_wrap[DIM_BANK])
    );

    dim_stepper #(.ADDR_W(RANK_W), .INC_W(RANK_W), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_rank (
        .clk_i, .rst_ni, .restart_i, .advance_i,
        .carry_i (dim_carry[DIM_RANK]),
        .start_i (rank_start_i), .wrap_i (rank_wrap),
        .inc_i   (rank_inc_i),   .rate_i (rank_rate_i),
        .addr_o  (rank_addr_o),  .wrap_o (dim_wrap[DIM_RANK])
    );

    rank_compactor #(.RANK_W(RANK_W)) u_rmap (
        .mask_i    (rank_mask_i),
        .logical_i (rank_addr_o),
        .map_o     (rank_map_o),
        .wrap_o    (rank_wrap),
        .phys_o    (phys_rank_o)
    );

    always_comb begin
        trig_d = |(dim_wrap & trig_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trig_q <= 1'b0;
        else         trig_q <= trig_d;
    end

    assign col_addr_o  = {col_q, {COL_SHIFT{1'b0}}};
    assign wrap_trig_o = trig_q;
endmodule

// File: rtl/test_addr_gen_checker.sv
module test_addr_gen_checker #(
    parameter int COL_W      = 8,
    parameter int ROW_W      = 16,
    parameter int BANK_W     = 3,
    parameter int RANK_W     = 3,
    parameter int RATE_W     = 8,
    localparam int NRANKS    = 1 << RANK_W
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 restart_i,
    input logic                 advance_i,
    input logic [COL_W-1:0]     col_start_i,
    input logic [ROW_W-1:0]     row_start_i,
    input logic [BANK_W-1:0]    bank_start_i,
    input logic [RANK_W-1:0]    rank_start_i,
    input logic [RATE_W-1:0]    col_rate_i,
    input logic [NRANKS-1:0]    rank_mask_i,
    input logic [3:0]           trig_en_i,
    input logic [COL_W+2:0]     col_addr_o,
    input logic [ROW_W-1:0]     row_addr_o,
    input logic [BANK_W-1:0]    bank_addr_o,
    input logic [RANK_W-1:0]    rank_addr_o,
    input logic [3:0]           phys_rank_o,
    input logic                 wrap_trig_o
);
    // R2: restart loads every start value
    p_restart_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (col_addr_o[COL_W+2:3] == $past(col_start_i))
                   && (row_addr_o == $past(row_start_i))
                   && (bank_addr_o == $past(bank_start_i))
                   && (rank_addr_o == $past(rank_start_i)));

    // R10: idle cycles hold every address
    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!advance_i && !restart_i) |=> $stable(col_addr_o) && $stable(row_addr_o)
                                    && $stable(bank_addr_o) && $stable(rank_addr_o));

    // R4: linear rate of zero freezes the column
    p_col_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (advance_i && !restart_i && col_rate_i == {1'b1, {(RATE_W-1){1'b0}}})
            |=> $stable(col_addr_o));

    // R8: trigger only after an advance with some trigger enabled
    p_trig_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_trig_o |-> $past(advance_i) && $past(|trig_en_i));

    // R9: a logical rank inside the selection maps to a selected physical rank
    p_map_selected_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(rank_addr_o) < $countones(rank_mask_i))
            |-> rank_mask_i[phys_rank_o[RANK_W-1:0]]);
endmodule

bind test_addr_gen test_addr_gen_checker #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .RANK_W(RANK_W), .RATE_W(RATE_W)
) u_checker (.*);

// File: tb/tb_test_addr_gen.sv
module tb_test_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0, advance = 1'b0;
    logic [7:0]  col_start, col_wrap, col_inc, col_rate;
    logic [15:0] row_start, row_wrap;
    logic [11:0] row_inc;
    logic [5:0]  row_rate;
    logic [2:0]  bank_start, bank_wrap, bank_inc, rank_start, rank_inc;
    logic [7:0]  bank_rate, rank_rate, rank_mask;
    logic [2:0]  carry_en;
    logic [3:0]  trig_en;
    logic [10:0] col_addr;
    logic [15:0] row_addr;
    logic [2:0]  bank_addr, rank_addr;
    logic [3:0]  phys_rank;
    logic [31:0] rank_map;
    logic        wrap_trig;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2.5ns clk = ~clk;

    test_addr_gen dut (
        .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .advance_i(advance),
        .col_start_i(col_start), .col_wrap_i(col_wrap), .col_inc_i(col_inc), .col_rate_i(col_rate),
        .row_start_i(row_start), .row_wrap_i(row_wrap), .row_inc_i(row_inc), .row_rate_i(row_rate),
        .bank_start_i(bank_start), .bank_wrap_i(bank_wrap), .bank_inc_i(bank_inc), .bank_rate_i(bank_rate),
        .rank_start_i(rank_start), .rank_inc_i(rank_inc), .rank_rate_i(rank_rate),
        .rank_mask_i(rank_mask), .carry_en_i(carry_en), .trig_en_i(trig_en),
        .col_addr_o(col_addr), .row_addr_o(row_addr), .bank_addr_o(bank_addr),
        .rank_addr_o(rank_addr), .phys_rank_o(phys_rank), .rank_map_o(rank_map),
        .wrap_trig_o(wrap_trig)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // all dimensions frozen, full ranges, unit increments
    task automatic defaults();
        col_start = 0; col_wrap = 8'hFF; col_inc = 1; col_rate = 8'h80;
        row_start = 0; row_wrap = 16'hFFFF; row_inc = 1; row_rate = 6'h20;
        bank_start = 0; bank_wrap = 7; bank_inc = 1; bank_rate = 8'h80;
        rank_start = 0; rank_inc = 1; rank_rate = 8'h80; rank_mask = 8'hFF;
        carry_en = 0; trig_en = 0;
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    // n advance cycles; returns at the negedge after the last active edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); advance = 1'b1;
        end
        @(negedge clk); advance = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 col", 32'(col_addr), 0);
        check("R1 row", 32'(row_addr), 0);
        check("R1 bank/rank", {bank_addr, rank_addr}, 0);
        check("R1 trig", 32'(wrap_trig), 0);
    endtask

    task automatic t_restart();
        defaults();
        col_start = 5; row_start = 100; bank_start = 2; rank_start = 1;
        do_restart();
        check("R2 col start", 32'(col_addr), 40);
        check("R2 row start", 32'(row_addr), 100);
        check("R2 bank start", 32'(bank_addr), 2);
        check("R2 rank start", 32'(rank_addr), 1);
        col_rate = 8'h81; row_rate = 6'h21;
        step(3);
        @(negedge clk); restart = 1'b1; advance = 1'b1;
        @(negedge clk); restart = 1'b0; advance = 1'b0;
        check("R2 restart over advance col", 32'(col_addr), 40);
        check("R2 restart over advance row", 32'(row_addr), 100);
    endtask

    task automatic t_linear();
        defaults();
        col_rate = 8'h81; col_inc = 3; row_rate = 6'h23; row_inc = 5;
        do_restart();
        step(4);
        check("R3 col x8 step", 32'(col_addr), 96);
        check("R4 row every 3rd", 32'(row_addr), 5);
        repeat (3) @(negedge clk);
        check("R10 col hold", 32'(col_addr), 96);
        check("R10 row hold", 32'(row_addr), 5);
        step(2);
        check("R4 row second update", 32'(row_addr), 10);
        check("R3 col after 6", 32'(col_addr), 144);
    endtask

    task automatic t_never();
        defaults();
        col_start = 9; bank_rate = 8'h80;
        do_restart();
        step(5);
        check("R4 col rate zero", 32'(col_addr), 72);
        check("R4 bank rate zero", 32'(bank_addr), 0);
    endtask

    task automatic t_exp();
        defaults();
        col_rate = 8'h02; row_rate = 6'h00; row_inc = 5; bank_rate = 8'h7F;
        do_restart();
        step(8);
        check("R5 col 2^2", 32'(col_addr), 16);
        check("R5 row 2^0", 32'(row_addr), 40);
        check("R5 bank 2^15 clamp", 32'(bank_addr), 0);
    endtask

    task automatic t_wrap();
        defaults();
        col_start = 2; col_wrap = 6; col_inc = 2; col_rate = 8'h81;
        do_restart();
        step(2);
        check("R6 equal to wrap kept", 32'(col_addr), 48);
        step(1);
        check("R6 past wrap reloads", 32'(col_addr), 16);
    endtask

    task automatic t_carry();
        defaults();
        col_wrap = 1; col_rate = 8'h81; row_wrap = 100; carry_en = 3'b001;
        do_restart();
        step(2);
        check("R7 col wrapped", 32'(col_addr), 0);
        check("R7 carry into row", 32'(row_addr), 1);
        carry_en = 3'b000;
        step(2);
        check("R7 carry disabled", 32'(row_addr), 1);
        row_wrap = 0; carry_en = 3'b011;
        do_restart();
        step(4);
        check("R7 ripple into bank", 32'(bank_addr), 2);
        check("R7 row reloaded", 32'(row_addr), 0);
        defaults();
        col_wrap = 0; col_rate = 8'h81; row_rate = 6'h21; row_wrap = 100; carry_en = 3'b001;
        do_restart();
        step(3);
        check("R7 tick plus carry single step", 32'(row_addr), 3);
    endtask

    task automatic t_trig();
        defaults();
        col_wrap = 1; col_rate = 8'h81; trig_en = 4'b0001;
        do_restart();
        step(1);
        check("R8 no wrap no trig", 32'(wrap_trig), 0);
        step(1);
        check("R8 trig after wrap", 32'(wrap_trig), 1);
        @(negedge clk);
        check("R8 trig one cycle", 32'(wrap_trig), 0);
        trig_en = 4'b1110;
        step(2);
        check("R8 disabled dim no trig", 32'(wrap_trig), 0);
    endtask

    task automatic t_rankmap();
        defaults();
        rank_mask = 8'b1010_0100; rank_rate = 8'h81;
        do_restart();
        check("R9 map", rank_map, 32'h0000_0752);
        check("R9 phys 0", 32'(phys_rank), 2);
        step(1);
        check("R9 phys 1", 32'(phys_rank), 5);
        step(1);
        check("R9 phys 2", 32'(phys_rank), 7);
        step(1);
        check("R9 wrap at count-1", 32'(rank_addr), 0);
        check("R9 phys after wrap", 32'(phys_rank), 2);
        rank_mask = 8'h00;
        @(negedge clk);
        check("R9 empty map", rank_map, 0);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_restart();
        t_linear();
        t_never();
        t_exp();
        t_wrap();
        t_carry();
        t_trig();
        t_rankmap();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule